// File: doc/BRIEF.md
# Trap Entry Register Update Unit

This block commits the architectural register writes that happen when a hypervisor-capable core takes a trap. It is given the trap cause, a flag that marks the trap as asynchronous, the pc of the trapping instruction, the faulting virtual address, the guest physical address, and the transformed instruction word produced elsewhere. It is also given the two delegation masks and the two trap vector registers. From these it picks the supervisor or the machine bank. It then writes that bank's exception pc, trap value, second-stage address value and transformed-instruction register, computes the handler pc, and reports the new privilege level. All of this happens on one clock edge while the take strobe is high.

A small fault-recording latch sits beside the trap logic. Address translation and the bus report faults into it. It remembers whether the fault came from a two-stage lookup, and whether it was a guest-stage miss during a guest page-table walk. A later trap then reports a fixed pseudoinstruction in place of the transformed instruction, and the trap clears both remembered flags.

Top module: `trap_entry_csr`

## Requirements
- R1: The delegation mask is `mideleg_i` for an asynchronous trap and `medeleg_i` for a synchronous one. If the mask bit indexed by the cause is set, the trap goes to supervisor level and `priv_o` becomes 1. Otherwise it goes to machine level and `priv_o` becomes 3.
- R2: For a synchronous data-class cause (4, 5, 6, 7, 13, 15, 21 or 23), the trap value is `addr_i` and the instruction register receives `xinst_i`, provided the latched walk flag is clear.
- R3: For any data-class or fetch-class cause taken while the latched walk flag is set, the instruction register receives 0x00002000 when XLEN is 32 and 0x00003000 when XLEN is 64.
- R4: For a synchronous fetch-class cause (0, 1, 12 or 20), the trap value is `addr_i` and the instruction register receives zero, provided the latched walk flag is clear.
- R5: For any other cause, and for every asynchronous trap, the trap value, the second-stage value and the instruction register are all written as zero.
- R6: A supervisor-level trap writes `sepc_o`, `stval_o`, `htval_o` and `htinst_o` and leaves the machine bank unchanged. A machine-level trap writes `mepc_o`, `mtval_o`, `mtval2_o` and `mtinst_o` and leaves the supervisor bank unchanged. The exception pc always takes `pc_i`.
- R7: The new pc is the selected vector register (`stvec_i` or `mtvec_i`) with bits 1:0 cleared. When the trap is asynchronous and those two bits equal 01, cause × 4 is added.
- R8: Taking a trap clears the latched two-stage and walk flags on the same edge. A fault record presented in the same cycle as a take is dropped, and `acc_o` is kept.
- R9: A fault record of kind 0 (translation failure) loads the two-stage flag and the walk flag from its inputs. If its walk input is set, the recorded access type becomes 1 (load); otherwise it is taken from `rec_acc_i`. Record kinds 1 (bus error) and 2 (misaligned) load the two-stage flag but always clear the walk flag. Access type codes are 0 fetch, 1 load and 2 store.
- R10: While `take_i` is low, no trap register, `pc_o` or `priv_o` changes.
- R11: After reset all trap registers are zero, `priv_o` is 3, `pc_o` is 0x1000, both latched flags are clear and `acc_o` is 0.
- R12: For data-class and fetch-class causes, the second-stage register of the selected bank receives `gpa_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Trap-take strobe |
| async_i | input | 1 | Trap is an interrupt |
| cause_i | input | CAUSE_W | Trap cause code |
| pc_i | input | XLEN | pc of the trapping instruction |
| addr_i | input | XLEN | Faulting virtual address |
| gpa_i | input | XLEN | Guest physical address value for the second-stage register |
| xinst_i | input | XLEN | Transformed instruction word |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| medeleg_i | input | XLEN | Exception delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector |
| rec_i | input | 1 | Fault-record strobe |
| rec_kind_i | input | 2 | Record kind: 0 translation, 1 bus, 2 misaligned |
| rec_acc_i | input | 2 | Access type of the fault |
| rec_two_stage_i | input | 1 | Fault came from a two-stage lookup |
| rec_walk_i | input | 1 | Guest-stage miss during a guest table walk |
| sepc_o | output | XLEN | Supervisor exception pc |
| stval_o | output | XLEN | Supervisor trap value |
| htval_o | output | XLEN | Supervisor-bank second-stage value |
| htinst_o | output | XLEN | Supervisor-bank instruction value |
| mepc_o | output | XLEN | Machine exception pc |
| mtval_o | output | XLEN | Machine trap value |
| mtval2_o | output | XLEN | Machine-bank second-stage value |
| mtinst_o | output | XLEN | Machine-bank instruction value |
| pc_o | output | XLEN | Handler pc |
| priv_o | output | 2 | Current privilege level |
| two_stage_o | output | 1 | Latched two-stage flag |
| walk_o | output | 1 | Latched walk flag |
| acc_o | output | 2 | Latched access type |

## Verification
The bench builds two copies side by side from the same stimulus: one with XLEN 64 and one with XLEN 32, both with CAUSE_W 5. The wider copy reaches the 0x00003000 pseudoinstruction and full 64-bit vector arithmetic. The narrow copy reaches the 0x00002000 variant, truncation of the inputs, and delegation bits up to index 31. A cause width of 5 lets the random stimulus hit every delegation bit of the narrow copy and every vectored offset up to 124.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   typedef enum logic [1:0] {
      CLS_OTHER = 2'd0,
      CLS_DATA  = 2'd1,
      CLS_FETCH = 2'd2
   } tcls_e;

   typedef enum logic [1:0] {
      FK_XLATE = 2'd0,
      FK_BUS   = 2'd1,
      FK_MISAL = 2'd2
   } fkind_e;

   localparam logic [1:0] ACC_FETCH = 2'd0;
   localparam logic [1:0] ACC_LOAD  = 2'd1;
   localparam logic [1:0] ACC_STORE = 2'd2;

   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   // Sort a cause into the class that decides which values are recorded.
   function automatic tcls_e classify(input logic [7:0] code, input logic is_async);
      if (is_async) return CLS_OTHER;
      case (code)
         8'd4, 8'd5, 8'd6, 8'd7, 8'd13, 8'd15, 8'd21, 8'd23: return CLS_DATA;
         8'd0, 8'd1, 8'd12, 8'd20:                           return CLS_FETCH;
         default:                                            return CLS_OTHER;
      endcase
   endfunction

endpackage

// File: rtl/trap_fault_latch.sv
module trap_fault_latch
   import trap_entry_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_i,
   input  logic       rec_i,
   input  logic [1:0] rec_kind_i,
   input  logic [1:0] rec_acc_i,
   input  logic       rec_two_stage_i,
   input  logic       rec_walk_i,
   output logic       two_stage_o,
   output logic       walk_o,
   output logic [1:0] acc_o
);

   logic       ts_q;
   logic       wk_q;
   logic [1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts_q  <= 1'b0;
         wk_q  <= 1'b0;
         acc_q <= ACC_FETCH;
      end else if (take_i) begin
         ts_q <= 1'b0;
         wk_q <= 1'b0;
      end else if (rec_i) begin
         ts_q <= rec_two_stage_i;
         if (rec_kind_i == FK_XLATE) begin
            wk_q  <= rec_walk_i;
            acc_q <= rec_walk_i ? ACC_LOAD : rec_acc_i;
         end else begin
            wk_q  <= 1'b0;
            acc_q <= rec_acc_i;
         end
      end
   end

   assign two_stage_o = ts_q;
   assign walk_o      = wk_q;
   assign acc_o       = acc_q;

   assert_take_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (!ts_q && !wk_q));

   assert_walk_is_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_i && !take_i && rec_kind_i == FK_XLATE && rec_walk_i) |=> (wk_q && acc_q == ACC_LOAD));

   assert_bus_clears_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_i && !take_i && rec_kind_i != FK_XLATE) |=> !wk_q);

endmodule

// File: rtl/trap_route.sv
module trap_route #(
   parameter int XLEN    = 64,
   parameter int CAUSE_W = 5
) (
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [XLEN-1:0]    mideleg_i,
   input  logic [XLEN-1:0]    medeleg_i,
   input  logic [XLEN-1:0]    stvec_i,
   input  logic [XLEN-1:0]    mtvec_i,
   output logic               to_s_o,
   output logic [XLEN-1:0]    npc_o
);

   localparam int PAD_W = XLEN - CAUSE_W - 2;

   logic [XLEN-1:0] deleg;
   logic [XLEN-1:0] tvec;
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   always_comb begin
      deleg  = async_i ? mideleg_i : medeleg_i;
      to_s_o = deleg[cause_i];
      tvec   = to_s_o ? stvec_i : mtvec_i;
      base   = {tvec[XLEN-1:2], 2'b00};
      offset = (async_i && tvec[1:0] == 2'b01) ? {{PAD_W{1'b0}}, cause_i, 2'b00} : '0;
      npc_o  = base + offset;
   end

endmodule

// File: rtl/trap_value_sel.sv
module trap_value_sel
   import trap_entry_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int CAUSE_W = 5
) (
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic               walk_i,
   input  logic [XLEN-1:0]    addr_i,
   input  logic [XLEN-1:0]    gpa_i,
   input  logic [XLEN-1:0]    xinst_i,
   output tcls_e              cls_o,
   output logic [XLEN-1:0]    tval_o,
   output logic [XLEN-1:0]    t2_o,
   output logic [XLEN-1:0]    tinst_o
);

   logic [XLEN-1:0] pseudo;

   generate
      if (XLEN == 32) begin : g_pseudo32
         assign pseudo = XLEN'(32'h0000_2000);
      end else begin : g_pseudo64
         assign pseudo = XLEN'(32'h0000_3000);
      end
   endgenerate

   always_comb begin
      cls_o   = classify(8'(cause_i), async_i);
      tval_o  = '0;
      t2_o    = '0;
      tinst_o = '0;
      case (cls_o)
         CLS_DATA: begin
            tval_o  = addr_i;
            t2_o    = gpa_i;
            tinst_o = walk_i ? pseudo : xinst_i;
         end
         CLS_FETCH: begin
            tval_o  = addr_i;
            t2_o    = gpa_i;
            tinst_o = walk_i ? pseudo : '0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/trap_entry_csr.sv
module trap_entry_csr
   import trap_entry_pkg::*;
#(
   parameter int              XLEN     = 64,
   parameter int              CAUSE_W  = 5,
   parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h0000_1000)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [XLEN-1:0]    addr_i,
   input  logic [XLEN-1:0]    gpa_i,
   input  logic [XLEN-1:0]    xinst_i,
   input  logic [XLEN-1:0]    mideleg_i,
   input  logic [XLEN-1:0]    medeleg_i,
   input  logic [XLEN-1:0]    stvec_i,
   input  logic [XLEN-1:0]    mtvec_i,
   input  logic               rec_i,
   input  logic [1:0]         rec_kind_i,
   input  logic [1:0]         rec_acc_i,
   input  logic               rec_two_stage_i,
   input  logic               rec_walk_i,
   output logic [XLEN-1:0]    sepc_o,
   output logic [XLEN-1:0]    stval_o,
   output logic [XLEN-1:0]    htval_o,
   output logic [XLEN-1:0]    htinst_o,
   output logic [XLEN-1:0]    mepc_o,
   output logic [XLEN-1:0]    mtval_o,
   output logic [XLEN-1:0]    mtval2_o,
   output logic [XLEN-1:0]    mtinst_o,
   output logic [XLEN-1:0]    pc_o,
   output logic [1:0]         priv_o,
   output logic               two_stage_o,
   output logic               walk_o,
   output logic [1:0]         acc_o
);

   localparam int              NBANK     = 2;
   localparam int              BANK_S    = 0;
   localparam logic [XLEN-1:0] PSEUDO_TI = (XLEN == 32) ? XLEN'(32'h0000_2000) : XLEN'(32'h0000_3000);

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("trap_entry_csr: XLEN must be 32 or 64");
      end
      if (CAUSE_W < 1 || CAUSE_W > 8 || (1 << CAUSE_W) > XLEN) begin : g_bad_cause
         $error("trap_entry_csr: CAUSE_W must index a delegation bit and fit 8 bits");
      end
   endgenerate

   logic            to_s;
   logic [XLEN-1:0] npc;
   tcls_e           cls;
   logic [XLEN-1:0] nx_tval, nx_t2, nx_tinst;
   logic            walk_q;
   logic [XLEN-1:0] pc_q;
   logic [1:0]      priv_q;

   trap_fault_latch u_latch (
      .clk             (clk),
      .rst_n           (rst_n),
      .take_i          (take_i),
      .rec_i           (rec_i),
      .rec_kind_i      (rec_kind_i),
      .rec_acc_i       (rec_acc_i),
      .rec_two_stage_i (rec_two_stage_i),
      .rec_walk_i      (rec_walk_i),
      .two_stage_o     (two_stage_o),
      .walk_o          (walk_q),
      .acc_o           (acc_o)
   );

   trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
      .async_i   (async_i),
      .cause_i   (cause_i),
      .mideleg_i (mideleg_i),
      .medeleg_i (medeleg_i),
      .stvec_i   (stvec_i),
      .mtvec_i   (mtvec_i),
      .to_s_o    (to_s),
      .npc_o     (npc)
   );

   trap_value_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vsel (
      .async_i (async_i),
      .cause_i (cause_i),
      .walk_i  (walk_q),
      .addr_i  (addr_i),
      .gpa_i   (gpa_i),
      .xinst_i (xinst_i),
      .cls_o   (cls),
      .tval_o  (nx_tval),
      .t2_o    (nx_t2),
      .tinst_o (nx_tinst)
   );

   // One register bank per target level; bank 0 is supervisor, bank 1 machine.
   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         localparam logic IS_S = (b == BANK_S);
         logic            sel;
         logic [XLEN-1:0] epc_q, tval_q, t2_q, ti_q;

         assign sel = take_i && (to_s == IS_S);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               epc_q  <= '0;
               tval_q <= '0;
               t2_q   <= '0;
               ti_q   <= '0;
            end else if (sel) begin
               epc_q  <= pc_i;
               tval_q <= nx_tval;
               t2_q   <= nx_t2;
               ti_q   <= nx_tinst;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         priv_q <= PRIV_M;
      end else if (take_i) begin
         pc_q   <= npc;
         priv_q <= to_s ? PRIV_S : PRIV_M;
      end
   end

   assign sepc_o   = g_bank[0].epc_q;
   assign stval_o  = g_bank[0].tval_q;
   assign htval_o  = g_bank[0].t2_q;
   assign htinst_o = g_bank[0].ti_q;
   assign mepc_o   = g_bank[1].epc_q;
   assign mtval_o  = g_bank[1].tval_q;
   assign mtval2_o = g_bank[1].t2_q;
   assign mtinst_o = g_bank[1].ti_q;
   assign pc_o     = pc_q;
   assign priv_o   = priv_q;
   assign walk_o   = walk_q;

   assert_priv_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_q == PRIV_S || priv_q == PRIV_M));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> ($stable(pc_q) && $stable(priv_q) && $stable(sepc_o) && $stable(mepc_o)
                   && $stable(htinst_o) && $stable(mtinst_o) && $stable(stval_o) && $stable(mtval_o)));

   assert_s_keeps_m_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && to_s) |=> ($stable(mepc_o) && $stable(mtval_o) && $stable(mtval2_o) && $stable(mtinst_o)));

   assert_m_keeps_s_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !to_s) |=> ($stable(sepc_o) && $stable(stval_o) && $stable(htval_o) && $stable(htinst_o)));

   assert_pseudo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && walk_q && cls != CLS_OTHER) |=> (((priv_q == PRIV_S) ? htinst_o : mtinst_o) == PSEUDO_TI));

   assert_other_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cls == CLS_OTHER) |=>
         (((priv_q == PRIV_S) ? (stval_o | htval_o | htinst_o) : (mtval_o | mtval2_o | mtinst_o)) == '0));

   assert_sync_pc_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !async_i) |=> (pc_q[1:0] == 2'b00));

endmodule

// File: tb/sim_trap_entry_csr.sv
`timescale 1ns/1ps
module sim_trap_entry_csr;

   typedef struct packed {
      logic [63:0] sepc, stval, htval, htinst, mepc, mtval, mtval2, mtinst, pc;
      logic [1:0]  priv;
      logic        ts, wk;
      logic [1:0]  acc;
   } mst_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        take, asy, rec, rts, rwk;
   logic [4:0]  cause;
   logic [1:0]  rkind, racc;
   logic [63:0] pc, addr, gpa, xinst, mid, med, stv, mtv;

   logic [63:0] a0 [9];
   logic [31:0] a1 [9];
   logic [1:0]  priv0, priv1, acc0, acc1;
   logic        ts0, ts1, wk0, wk1;

   int nchk = 0;
   int nbad = 0;
   bit done = 1'b0;

   string t_epc, t_val, t_ins, t_t2, t_pc, t_priv, t_flg;

   mst_t m0, m1;

   trap_entry_csr #(.XLEN(64), .CAUSE_W(5)) u0 (
      .clk(clk), .rst_n(rst_n), .take_i(take), .async_i(asy), .cause_i(cause),
      .pc_i(pc), .addr_i(addr), .gpa_i(gpa), .xinst_i(xinst),
      .mideleg_i(mid), .medeleg_i(med), .stvec_i(stv), .mtvec_i(mtv),
      .rec_i(rec), .rec_kind_i(rkind), .rec_acc_i(racc),
      .rec_two_stage_i(rts), .rec_walk_i(rwk),
      .sepc_o(a0[0]), .stval_o(a0[1]), .htval_o(a0[2]), .htinst_o(a0[3]),
      .mepc_o(a0[4]), .mtval_o(a0[5]), .mtval2_o(a0[6]), .mtinst_o(a0[7]),
      .pc_o(a0[8]), .priv_o(priv0), .two_stage_o(ts0), .walk_o(wk0), .acc_o(acc0)
   );

   trap_entry_csr #(.XLEN(32), .CAUSE_W(5)) u1 (
      .clk(clk), .rst_n(rst_n), .take_i(take), .async_i(asy), .cause_i(cause),
      .pc_i(pc[31:0]), .addr_i(addr[31:0]), .gpa_i(gpa[31:0]), .xinst_i(xinst[31:0]),
      .mideleg_i(mid[31:0]), .medeleg_i(med[31:0]), .stvec_i(stv[31:0]), .mtvec_i(mtv[31:0]),
      .rec_i(rec), .rec_kind_i(rkind), .rec_acc_i(racc),
      .rec_two_stage_i(rts), .rec_walk_i(rwk),
      .sepc_o(a1[0]), .stval_o(a1[1]), .htval_o(a1[2]), .htinst_o(a1[3]),
      .mepc_o(a1[4]), .mtval_o(a1[5]), .mtval2_o(a1[6]), .mtinst_o(a1[7]),
      .pc_o(a1[8]), .priv_o(priv1), .two_stage_o(ts1), .walk_o(wk1), .acc_o(acc1)
   );

   // Cause class from the requirement text: 1 data, 2 fetch, 0 other.
   function automatic int bcls(input logic [4:0] c, input logic as);
      if (as) return 0;
      if (c inside {5'd4, 5'd5, 5'd6, 5'd7, 5'd13, 5'd15, 5'd21, 5'd23}) return 1;
      if (c inside {5'd0, 5'd1, 5'd12, 5'd20}) return 2;
      return 0;
   endfunction

   function automatic mst_t reset_state();
      mst_t r;
      r = '0;
      r.pc   = 64'h1000;
      r.priv = 2'd3;
      return r;
   endfunction

   function automatic mst_t mstep(input mst_t s, input int xl);
      mst_t        r;
      logic [63:0] msk, dl, tv, t2, ti, epc, vec, npc, pseudo;
      logic        tos;
      int          k;
      r      = s;
      msk    = (xl == 32) ? 64'h0000_0000_FFFF_FFFF : '1;
      pseudo = (xl == 32) ? 64'h2000 : 64'h3000;
      if (take) begin
         dl  = (asy ? mid : med) & msk;
         tos = dl[cause];
         k   = bcls(cause, asy);
         tv  = (k != 0) ? (addr & msk) : 64'd0;
         t2  = (k != 0) ? (gpa & msk) : 64'd0;
         if (k == 1)      ti = s.wk ? pseudo : (xinst & msk);
         else if (k == 2) ti = s.wk ? pseudo : 64'd0;
         else             ti = 64'd0;
         epc = pc & msk;
         vec = (tos ? stv : mtv) & msk;
         npc = (vec & ~64'd3) + ((asy && vec[1:0] == 2'b01) ? (64'(cause) * 4) : 64'd0);
         if (tos) begin
            r.sepc = epc; r.stval = tv; r.htval = t2; r.htinst = ti; r.priv = 2'd1;
         end else begin
            r.mepc = epc; r.mtval = tv; r.mtval2 = t2; r.mtinst = ti; r.priv = 2'd3;
         end
         r.pc = npc & msk;
         r.ts = 1'b0;
         r.wk = 1'b0;
      end else if (rec) begin
         r.ts = rts;
         if (rkind == 2'd0) begin
            r.wk  = rwk;
            r.acc = rwk ? 2'd1 : racc;
         end else begin
            r.wk  = 1'b0;
            r.acc = racc;
         end
      end
      return r;
   endfunction

   task automatic chk(input string tag, input string inst, input string nm,
                      input logic [63:0] got, input logic [63:0] exp);
      nchk++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s %s.%s got=%h exp=%h", tag, inst, nm, got, exp);
      end
   endtask

   task automatic cmp(input string inst, input mst_t a, input mst_t e);
      chk(t_epc,  inst, "sepc",   a.sepc,   e.sepc);
      chk(t_val,  inst, "stval",  a.stval,  e.stval);
      chk(t_t2,   inst, "htval",  a.htval,  e.htval);
      chk(t_ins,  inst, "htinst", a.htinst, e.htinst);
      chk(t_epc,  inst, "mepc",   a.mepc,   e.mepc);
      chk(t_val,  inst, "mtval",  a.mtval,  e.mtval);
      chk(t_t2,   inst, "mtval2", a.mtval2, e.mtval2);
      chk(t_ins,  inst, "mtinst", a.mtinst, e.mtinst);
      chk(t_pc,   inst, "pc",     a.pc,     e.pc);
      chk(t_priv, inst, "priv",   64'(a.priv), 64'(e.priv));
      chk(t_flg,  inst, "two_stage", 64'(a.ts), 64'(e.ts));
      chk(t_flg,  inst, "walk",   64'(a.wk),  64'(e.wk));
      chk(t_flg,  inst, "acc",    64'(a.acc), 64'(e.acc));
   endtask

   function automatic mst_t act0();
      mst_t r;
      r = {a0[0], a0[1], a0[2], a0[3], a0[4], a0[5], a0[6], a0[7], a0[8], priv0, ts0, wk0, acc0};
      return r;
   endfunction

   function automatic mst_t act1();
      mst_t r;
      r = {32'd0, a1[0], 32'd0, a1[1], 32'd0, a1[2], 32'd0, a1[3], 32'd0, a1[4],
           32'd0, a1[5], 32'd0, a1[6], 32'd0, a1[7], 32'd0, a1[8], priv1, ts1, wk1, acc1};
      return r;
   endfunction

   function automatic string ctag(input int k);
      return (k == 1) ? "R2" : (k == 2) ? "R4" : "R5";
   endfunction

   task automatic set_tags();
      int k;
      k = bcls(cause, asy);
      if (take) begin
         t_epc  = "R6";
         t_val  = ctag(k);
         t_ins  = (k != 0 && m0.wk) ? "R3" : ctag(k);
         t_t2   = (k != 0) ? "R12" : "R5";
         t_pc   = "R7";
         t_priv = "R1";
         t_flg  = "R8";
      end else begin
         t_epc = "R10"; t_val = "R10"; t_ins = "R10"; t_t2 = "R10";
         t_pc = "R10"; t_priv = "R10";
         t_flg = rec ? "R9" : "R10";
      end
   endtask

   // Inputs are set at a falling edge; the model advances across the rising
   // edge and outputs are compared at the following falling edge.
   task automatic cycle();
      mst_t n0, n1;
      set_tags();
      n0 = mstep(m0, 64);
      n1 = mstep(m1, 32);
      @(posedge clk);
      @(negedge clk);
      m0 = n0;
      m1 = n1;
      cmp("u0", act0(), m0);
      cmp("u1", act1(), m1);
   endtask

   task automatic idle_inputs();
      take = 0; asy = 0; rec = 0; rts = 0; rwk = 0; cause = '0;
      rkind = '0; racc = '0;
      pc = '0; addr = '0; gpa = '0; xinst = '0; mid = '0; med = '0; stv = '0; mtv = '0;
   endtask

   function automatic logic [63:0] r64();
      return {$urandom, $urandom};
   endfunction

   task automatic rand_inputs();
      int sel;
      take  = ($urandom % 2) == 0;
      asy   = ($urandom % 4) == 0;
      sel   = $urandom % 4;
      case (sel)
         0: case ($urandom % 8)
               0: cause = 5'd4;  1: cause = 5'd5;  2: cause = 5'd6;  3: cause = 5'd7;
               4: cause = 5'd13; 5: cause = 5'd15; 6: cause = 5'd21; default: cause = 5'd23;
            endcase
         1: case ($urandom % 4)
               0: cause = 5'd0; 1: cause = 5'd1; 2: cause = 5'd12; default: cause = 5'd20;
            endcase
         default: cause = 5'($urandom % 32);
      endcase
      rec   = ($urandom % 2) == 0;
      rkind = 2'($urandom % 3);
      racc  = 2'($urandom % 3);
      rts   = 1'($urandom);
      rwk   = 1'($urandom);
      pc = r64(); addr = r64(); gpa = r64(); xinst = r64();
      mid = r64(); med = r64(); stv = r64(); mtv = r64();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      idle_inputs();
      m0 = reset_state();
      m1 = reset_state();
      repeat (3) @(negedge clk);
      // R11: reset values
      t_epc = "R11"; t_val = "R11"; t_ins = "R11"; t_t2 = "R11";
      t_pc = "R11"; t_priv = "R11"; t_flg = "R11";
      cmp("u0", act0(), m0);
      cmp("u1", act1(), m1);
      rst_n = 1'b1;
      cycle();

      // R9: translation failure during walk -> flag set, access becomes load
      idle_inputs(); rec = 1; rkind = 2'd0; racc = 2'd2; rts = 1; rwk = 1;
      cycle();
      // R3: data fault with walk flag set, delegated to supervisor
      idle_inputs(); take = 1; cause = 5'd13; med = 64'h2000;
      pc = 64'hFFFF_0000_1234_5670; addr = 64'h8000_0000_0000_0ABC; gpa = 64'h55;
      xinst = 64'hDEAD_BEEF; stv = 64'h0000_0000_8000_0003;
      cycle();
      // R9: bus error with walk input set still leaves walk clear
      idle_inputs(); rec = 1; rkind = 2'd1; racc = 2'd0; rts = 1; rwk = 1;
      cycle();
      // R8: record and take in the same cycle -> record dropped
      idle_inputs(); rec = 1; rkind = 2'd0; racc = 2'd2; rts = 1; rwk = 1;
      take = 1; cause = 5'd2; mtv = 64'h4000;
      cycle();
      // R7: vectored interrupt to machine level
      idle_inputs(); take = 1; asy = 1; cause = 5'd7; mtv = 64'h0000_0000_0000_2001;
      cycle();
      // R7: direct mode interrupt, no offset
      idle_inputs(); take = 1; asy = 1; cause = 5'd11; mtv = 64'h0000_0000_0000_3000;
      cycle();
      // R4: fetch fault without walk flag, supervisor-delegated
      idle_inputs(); take = 1; cause = 5'd12; med = 64'h1000; addr = 64'h1234;
      xinst = 64'hFFFF_FFFF; stv = 64'h0000_0000_9000_0001;
      cycle();
      // R3 for fetch class: set walk then take a guest instruction page fault
      idle_inputs(); rec = 1; rkind = 2'd0; racc = 2'd0; rts = 1; rwk = 1;
      cycle();
      idle_inputs(); take = 1; cause = 5'd20; addr = 64'h7777; gpa = 64'h99;
      cycle();
      // R1: interrupt uses mideleg, ignoring medeleg
      idle_inputs(); take = 1; asy = 1; cause = 5'd9; mid = 64'h200; med = 64'h0;
      stv = 64'h0000_0000_4000_0001;
      cycle();
      // R10: quiet cycle with busy inputs
      idle_inputs(); pc = r64(); addr = r64(); stv = r64(); mtv = r64();
      cycle();

      for (int i = 0; i < 3000; i++) begin
         rand_inputs();
         cycle();
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule